// File: doc/BRIEF.md
# Toggle-Limited Scan Pattern Generator

This block supplies pseudo-random stimulus to a bank of scan chains while keeping the shift-in switching activity at a level set by software. A 16-bit maximal-length LFSR produces random bits. A control shift register holds one enable bit per chain. A chain whose enable bit is set takes a new phase-shifted random bit on each shift. A chain whose bit is clear repeats the bit it gave on the previous shift. The density of ones that enter the control register comes from a 4-bit weighting code. As the code changes, the share of chains that toggle moves from none to about 69 percent.

A small phase controller, made of a 4-bit down counter and a mode flip-flop, alternates between two phases. In the toggle phase the control register takes one new bit per shift. In the hold phase the register stays frozen. A pattern start presets the counter with an offset and the mode flip-flop with an initial value. When the counter expires, the mode flips and the counter reloads from the toggle-length or hold-length input. A multiplexer can replace the weighted bit with a serial bit supplied from outside, so that the control register can be filled deterministically. A pattern-done pulse marks the end of each scan load of programmable length.

Top module: `lp_pattern_gen`

## Requirements
- R1: While rst_ni is low, scan_o, ctrl_o, mode_o and pattern_done_o are all 0.
- R2: An active shift is a cycle with shift_en_i=1, start_i=0 and seed_load_i=0. On an active shift, a chain whose ctrl_o bit is 0 keeps its scan_o bit. A chain whose ctrl_o bit is 1 takes a fresh pseudo-random bit.
- R3: On an active shift with mode_o=1 (toggle phase), ctrl_o shifts toward its MSB and the new bit enters bit 0. With mode_o=0 (hold phase), ctrl_o does not change.
- R4: With det_sel_i=0, the new control bit is the OR of terms, where code_i bit i enables an AND of i+1 independent random bits. Code 0 therefore gives only zeros, code 1 gives 0.5, code 8 gives 0.0625 and code 15 gives about 0.692.
- R5: With det_sel_i=1, the bit that enters ctrl_o bit 0 on a toggle-phase shift is det_bit_i, so the bit fed first ends up in the MSB.
- R6: start_i sets mode_o to init_mode_i on the next cycle. The first phase then lasts offset_i+1 active shifts.
- R7: After the first phase, each toggle phase lasts toggle_len_i+1 active shifts and each hold phase lasts hold_len_i+1 active shifts. mode_o changes only on an active shift or on start_i.
- R8: seed_load_i loads seed_i into the LFSR, except that a seed of 0 is replaced by 16'hACE1, so the LFSR never holds zero.
- R9: pattern_done_o is high for one cycle after every chain_len_i-th active shift counted from start_i.
- R10: A cycle that is not an active shift changes neither scan_o nor ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load seed_i into the LFSR |
| seed_i | input | 16 | LFSR seed |
| start_i | input | 1 | Pattern start: preset the counter and mode, clear the shift count |
| shift_en_i | input | 1 | Shift enable |
| code_i | input | 4 | Weighting code |
| toggle_len_i | input | 4 | Counter preset for the toggle phase |
| hold_len_i | input | 4 | Counter preset for the hold phase |
| offset_i | input | 4 | Counter preset at pattern start |
| init_mode_i | input | 1 | First phase (1 = toggle) |
| det_sel_i | input | 1 | Feed det_bit_i instead of the weighted bit |
| det_bit_i | input | 1 | Deterministic control bit |
| chain_len_i | input | 8 | Shifts per pattern |
| scan_o | output | 8 | Scan-in bit for each chain |
| ctrl_o | output | 8 | Toggle-enable register |
| mode_o | output | 1 | Current phase (1 = toggle, 0 = hold) |
| pattern_done_o | output | 1 | End-of-load pulse |

## Verification
The bound checker checks the following on every cycle:
- chains with a clear enable bit never change;
- the control register is frozen in hold phase and on idle cycles;
- the shift-in bit follows the deterministic input or is zero for code 0;
- the start preset takes effect;
- the done pulse lasts a single cycle;
- the LFSR never becomes zero.

Only the bench scenarios can show the exact phase lengths after offsets and presets, the ones density for each weighting code, and the recovery from a zero seed.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int          LFSR_W        = 16;
  localparam logic [15:0] LFSR_TAPS     = 16'hB400; // x^16+x^14+x^13+x^11+1
  localparam logic [15:0] LFSR_FALLBACK = 16'hACE1;

  typedef enum logic {PH_HOLD = 1'b0, PH_TOGGLE = 1'b1} phase_e;
endpackage

// File: rtl/lp_lfsr.sv
module lp_lfsr
  import lp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = ^(state_q & LFSR_TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= LFSR_FALLBACK;
    else if (load_i)  state_q <= (seed_i == '0) ? LFSR_FALLBACK : seed_i;
    else if (step_i)  state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/lp_weight.sv
module lp_weight #(
  parameter int CODE_W = 4,
  parameter int RND_W  = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [RND_W-1:0]  rnd_i,
  output logic              bit_o
);
  localparam int NEED = CODE_W * (CODE_W + 1) / 2;

  logic [CODE_W-1:0] term;

  // term i: AND of i+1 disjoint random bits, probability 2^-(i+1)
  for (genvar i = 0; i < CODE_W; i++) begin : g_term
    localparam int BASE = i * (i + 1) / 2;
    assign term[i] = code_i[i] & (&rnd_i[BASE +: i+1]);
  end

  if (NEED > RND_W) begin : g_bad_width
    initial $error("lp_weight: random source too narrow");
  end

  assign bit_o = |term;
endmodule

// File: rtl/lp_phase_ctrl.sv
module lp_phase_ctrl
  import lp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic             init_mode_i,
  input  logic [CNT_W-1:0] toggle_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  output logic             mode_o
);
  logic [CNT_W-1:0] cnt_q;
  phase_e           mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= PH_HOLD;
    end else if (start_i) begin
      cnt_q  <= offset_i;
      mode_q <= phase_e'(init_mode_i);
    end else if (step_i) begin
      if (cnt_q == '0) begin
        mode_q <= (mode_q == PH_TOGGLE) ? PH_HOLD : PH_TOGGLE;
        cnt_q  <= (mode_q == PH_TOGGLE) ? hold_len_i : toggle_len_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign mode_o = (mode_q == PH_TOGGLE);
endmodule

// File: rtl/lp_pattern_gen.sv
module lp_pattern_gen
  import lp_pkg::*;
#(
  parameter int NUM_CHAINS = 8,
  parameter int CODE_W     = 4,
  parameter int CNT_W      = 4,
  parameter int LEN_W      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  seed_load_i,
  input  logic [LFSR_W-1:0]     seed_i,
  input  logic                  start_i,
  input  logic                  shift_en_i,
  input  logic [CODE_W-1:0]     code_i,
  input  logic [CNT_W-1:0]      toggle_len_i,
  input  logic [CNT_W-1:0]      hold_len_i,
  input  logic [CNT_W-1:0]      offset_i,
  input  logic                  init_mode_i,
  input  logic                  det_sel_i,
  input  logic                  det_bit_i,
  input  logic [LEN_W-1:0]      chain_len_i,
  output logic [NUM_CHAINS-1:0] scan_o,
  output logic [NUM_CHAINS-1:0] ctrl_o,
  output logic                  mode_o,
  output logic                  pattern_done_o
);
  localparam int PS_DIST = LFSR_W / 2;

  logic                  act;
  logic [LFSR_W-1:0]     lfsr_q;
  logic                  wbit, shift_in;
  logic [NUM_CHAINS-1:0] ctrl_q, scan_q, ps_bit;
  logic [LEN_W-1:0]      pos_q;
  logic                  done_q;

  assign act = shift_en_i & ~start_i & ~seed_load_i;

  lp_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .step_i  (act),
    .state_o (lfsr_q)
  );

  lp_weight #(.CODE_W(CODE_W), .RND_W(LFSR_W)) u_weight (
    .code_i (code_i),
    .rnd_i  (lfsr_q),
    .bit_o  (wbit)
  );

  lp_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .step_i       (act),
    .offset_i     (offset_i),
    .init_mode_i  (init_mode_i),
    .toggle_len_i (toggle_len_i),
    .hold_len_i   (hold_len_i),
    .mode_o       (mode_o)
  );

  assign shift_in = det_sel_i ? det_bit_i : wbit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= '0;
    else if (act && mode_o)    ctrl_q <= {ctrl_q[NUM_CHAINS-2:0], shift_in};
  end

  // XOR phase shifter and per-chain hold gate
  for (genvar j = 0; j < NUM_CHAINS; j++) begin : g_chain
    localparam int TA = j % LFSR_W;
    localparam int TB = (j + PS_DIST) % LFSR_W;
    assign ps_bit[j] = lfsr_q[TA] ^ lfsr_q[TB];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                scan_q[j] <= 1'b0;
      else if (act && ctrl_q[j])  scan_q[j] <= ps_bit[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (act) begin
      if (pos_q == LEN_W'(chain_len_i - 1'b1)) begin
        pos_q  <= '0;
        done_q <= 1'b1;
      end else begin
        pos_q  <= pos_q + 1'b1;
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign scan_o         = scan_q;
  assign ctrl_o         = ctrl_q;
  assign pattern_done_o = done_q;
endmodule

// File: rtl/lp_pattern_gen_chk.sv
module lp_pattern_gen_chk #(
  parameter int NUM_CHAINS = 8,
  parameter int CODE_W     = 4,
  parameter int LEN_W      = 8,
  parameter int LFSR_W     = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  seed_load_i,
  input logic                  start_i,
  input logic                  shift_en_i,
  input logic [CODE_W-1:0]     code_i,
  input logic                  init_mode_i,
  input logic                  det_sel_i,
  input logic                  det_bit_i,
  input logic [LEN_W-1:0]      chain_len_i,
  input logic [NUM_CHAINS-1:0] scan_o,
  input logic [NUM_CHAINS-1:0] ctrl_o,
  input logic                  mode_o,
  input logic                  pattern_done_o,
  input logic [LFSR_W-1:0]     lfsr_q
);
  logic act;
  assign act = shift_en_i && !start_i && !seed_load_i;

  assert_gated_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> ((scan_o ^ $past(scan_o)) & ~$past(ctrl_o)) == '0);

  assert_hold_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !mode_o) |=> $stable(ctrl_o));

  assert_code_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && mode_o && !det_sel_i && code_i == '0) |=> !ctrl_o[0]);

  assert_det_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && mode_o && det_sel_i) |=> ctrl_o[0] == $past(det_bit_i));

  assert_start_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> mode_o == $past(init_mode_i));

  assert_mode_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !act) |=> $stable(mode_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pattern_done_o && chain_len_i > 1) |=> !pattern_done_o);

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> ($stable(scan_o) && $stable(ctrl_o)));

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      assert_lfsr_nonzero_R8: assert (lfsr_q != '0);
    end
  end
endmodule

bind lp_pattern_gen lp_pattern_gen_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .CODE_W     (CODE_W),
  .LEN_W      (LEN_W),
  .LFSR_W     (lp_pkg::LFSR_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .seed_load_i    (seed_load_i),
  .start_i        (start_i),
  .shift_en_i     (shift_en_i),
  .code_i         (code_i),
  .init_mode_i    (init_mode_i),
  .det_sel_i      (det_sel_i),
  .det_bit_i      (det_bit_i),
  .chain_len_i    (chain_len_i),
  .scan_o         (scan_o),
  .ctrl_o         (ctrl_o),
  .mode_o         (mode_o),
  .pattern_done_o (pattern_done_o),
  .lfsr_q         (lfsr_q)
);

// File: tb/tb_lp_pattern_gen.sv
`timescale 1ns/100ps
module tb_lp_pattern_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        seed_load_i, start_i, shift_en_i, init_mode_i, det_sel_i, det_bit_i;
  logic [15:0] seed_i;
  logic [3:0]  code_i, toggle_len_i, hold_len_i, offset_i;
  logic [7:0]  chain_len_i;
  logic [7:0]  scan_o, ctrl_o;
  logic        mode_o, pattern_done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  lp_pattern_gen dut (.*);

  // {init_mode, offset, toggle_len, hold_len}
  localparam logic [12:0] PH_TAB [4] = '{
    {1'b1, 4'd0, 4'd0, 4'd0},
    {1'b0, 4'd3, 4'd1, 4'd2},
    {1'b1, 4'd2, 4'd4, 4'd0},
    {1'b0, 4'd0, 4'd5, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic do_start(input logic im, input logic [3:0] off, tl, hl);
    init_mode_i = im; offset_i = off; toggle_len_i = tl; hold_len_i = hl;
    shift_en_i = 1'b0; start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic weight_stat(input logic [3:0] code, input int lo, input int hi, input string req);
    int ones = 0;
    int n = 0;
    code_i = code; det_sel_i = 1'b0;
    do_start(1'b1, 4'd15, 4'd15, 4'd0);
    shift_en_i = 1'b1;
    for (int k = 0; k < 1200; k++) begin
      logic m;
      m = mode_o;
      step();
      if (m) begin
        n++;
        ones += int'(ctrl_o[0]);
      end
    end
    shift_en_i = 1'b0;
    chk((ones * 1000 / n) >= lo && (ones * 1000 / n) <= hi, req, ones * 1000 / n, lo);
  endtask

  initial begin
    #500us;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap, moved, pat;
    rst_ni = 1'b0; seed_load_i = 0; seed_i = 0; start_i = 0; shift_en_i = 0;
    init_mode_i = 0; det_sel_i = 0; det_bit_i = 0; code_i = 0;
    toggle_len_i = 0; hold_len_i = 0; offset_i = 0; chain_len_i = 8'd16;
    step(); step();
    // R1 reset state
    chk(scan_o == 0 && ctrl_o == 0 && mode_o == 0 && pattern_done_o == 0, "R1",
        {scan_o, ctrl_o, 7'd0, mode_o, 7'd0, pattern_done_o}, 0);
    rst_ni = 1'b1;
    step();

    // R6 R7: phase lengths from the table
    for (int e = 0; e < 4; e++) begin
      logic       m;
      logic [3:0] c;
      bit         ok = 1;
      m = PH_TAB[e][12];
      c = PH_TAB[e][11:8];
      do_start(PH_TAB[e][12], PH_TAB[e][11:8], PH_TAB[e][7:4], PH_TAB[e][3:0]);
      shift_en_i = 1'b1;
      for (int k = 0; k < 20; k++) begin
        if (mode_o !== m) ok = 0;
        step();
        if (c == 0) begin
          m = ~m;
          c = m ? PH_TAB[e][7:4] : PH_TAB[e][3:0];
        end else c--;
      end
      shift_en_i = 1'b0;
      chk(ok, "R6 R7 phase sequence", e, 1);
    end

    // R5: deterministic fill, then R6 first phase ends after offset+1 shifts
    pat = 8'b1010_0101;
    det_sel_i = 1'b1;
    do_start(1'b1, 4'd7, 4'd15, 4'd15);
    shift_en_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      det_bit_i = pat[7-k];
      step();
    end
    chk(ctrl_o == pat, "R5", ctrl_o, pat);
    chk(mode_o == 1'b0, "R6 first phase length", mode_o, 0);

    // R3 R2: hold phase freezes control, gated chains keep their bits
    snap = scan_o;
    moved = 0;
    det_bit_i = 1'b0;
    for (int k = 0; k < 15; k++) begin
      step();
      moved |= scan_o ^ snap;
    end
    chk(ctrl_o == pat, "R3 hold freeze", ctrl_o, pat);
    chk((moved & ~pat) == 0, "R2 gated chains", moved, 0);
    chk((moved & pat) != 0, "R2 enabled chains", moved, pat);

    // R10: idle and seed-load cycles change nothing
    snap = scan_o;
    shift_en_i = 1'b0;
    step(); step(); step();
    chk(scan_o == snap && ctrl_o == pat, "R10 idle", scan_o, snap);
    shift_en_i = 1'b1; seed_load_i = 1'b1; seed_i = 16'h1234;
    step();
    seed_load_i = 1'b0; shift_en_i = 1'b0;
    chk(scan_o == snap && ctrl_o == pat, "R10 seed load", scan_o, snap);

    // R9: done pulse every chain_len shifts
    chain_len_i = 8'd5;
    det_sel_i = 1'b0; code_i = 4'd1;
    do_start(1'b1, 4'd3, 4'd3, 4'd3);
    shift_en_i = 1'b1;
    for (int k = 1; k <= 11; k++) begin
      step();
      chk(pattern_done_o == (k % 5 == 0), "R9", pattern_done_o, (k % 5 == 0));
    end
    shift_en_i = 1'b0;
    chain_len_i = 8'd16;

    // R4: ones density per code
    weight_stat(4'h0, 0, 0, "R4 code 0");
    weight_stat(4'h1, 440, 560, "R4 code 1");
    weight_stat(4'h8, 30, 100, "R4 code 8");
    weight_stat(4'hF, 630, 750, "R4 code F");

    // R8: zero seed replaced, chains still receive nonzero data
    do_reset();
    seed_i = 16'h0000; seed_load_i = 1'b1;
    step();
    seed_load_i = 1'b0;
    det_sel_i = 1'b1; det_bit_i = 1'b1;
    do_start(1'b1, 4'd15, 4'd15, 4'd0);
    shift_en_i = 1'b1;
    for (int k = 0; k < 12; k++) step();
    shift_en_i = 1'b0;
    chk(ctrl_o == 8'hFF, "R5 all ones fill", ctrl_o, 8'hFF);
    chk(scan_o != 0, "R8 zero seed", scan_o, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule